// File: doc/BRIEF.md
# Isochronous Cycle Monitor

This block tracks the boundaries of isochronous cycles on a serial bus node. Each pulse from the local cycle timer opens a window in which a cycle-start packet is due. On a node configured as cycle master, the monitor asks the transmitter to send that packet. On any other node, it waits for a cycle-start packet to arrive from the bus. Once the packet has been sent or received, the window closes. If the next timer pulse comes while the window is still open, the cycle is declared lost and a fresh window opens at once.

The monitor keeps three sticky interrupt flags: cycle started, cycle lost and cycle done. Cycle done is reported when the bus reports a subaction gap while no window is open, which marks the end of the isochronous period. The host clears a flag by writing a one to its bit position. Packet formatting is not part of this block.

The controller has three states:
- **IDLE**: no window is open.
- **WAIT**: a window is open and a packet is expected from the bus.
- **SEND**: a window is open and the transmitter is being asked to send.

The transitions are:
- IDLE goes to SEND on a timer pulse when the node is master, and to WAIT on a timer pulse when it is not.
- WAIT or SEND goes back to IDLE on a sent or received strobe.
- WAIT or SEND re-enters SEND or WAIT on a timer pulse, chosen by the master bit. This is the lost case, unless a strobe comes in the same cycle.
- SEND drops to WAIT when the master bit is cleared.

Top module: `iso_cycle_monitor`

## Requirements
- R1: After reset, all three flags, `cycle_pending` and `send_cs_req` are 0.
- R2: A `cyc_tick` pulse sets `cycle_pending` from the next cycle. It stays set until a `cs_sent` or `cs_rcvd` strobe arrives, and clears in the cycle after the strobe.
- R3: When `master_en` is 1, a `cyc_tick` raises `send_cs_req` from the next cycle until the window closes. When `master_en` is 0, `send_cs_req` stays 0.
- R4: A `cs_sent` or `cs_rcvd` strobe sets flag bit 0 (cycle started) in the next cycle. This also holds for a strobe that arrives while no window is open.
- R5: A `cyc_tick` that arrives while `cycle_pending` is 1, with no strobe in the same cycle, sets flag bit 1 (cycle lost), and `cycle_pending` stays 1.
- R6: A strobe and a `cyc_tick` in the same cycle close the old window without loss. Bit 1 stays 0 and a new window is open in the next cycle.
- R7: `subact_gap` while `cycle_pending` is 0 sets flag bit 2 (cycle done). A gap while a window is open has no effect on the flags.
- R8: A one in bit i of `irq_clr` clears flag i in the next cycle. A zero in `irq_clr` leaves the flag unchanged.
- R9: When a flag's set event and its clear arrive in the same cycle, the flag ends up set.
- R10: Clearing `master_en` while `send_cs_req` is 1 drops the request in the next cycle, and `cycle_pending` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| master_en | input | 1 | Node acts as cycle master |
| cyc_tick | input | 1 | One-cycle pulse from the cycle timer |
| cs_sent | input | 1 | Strobe: a cycle-start packet was transmitted |
| cs_rcvd | input | 1 | Strobe: a cycle-start packet was received |
| subact_gap | input | 1 | Bus reports a subaction gap |
| irq_clr | input | 3 | Write-one-to-clear mask for the flags |
| irq_flags | output | 3 | Sticky flags: bit 0 started, bit 1 lost, bit 2 done |
| send_cs_req | output | 1 | Request to the transmitter to send a cycle-start packet |
| cycle_pending | output | 1 | A cycle-start window is open |

## Verification
A controller stuck in a window shows up as `cycle_pending` still high one cycle after a strobe. The first timer pulse after that then raises a spurious lost flag. If the state is stuck in IDLE, or a tick is missed, `cycle_pending` stays low in the cycle after the tick. A gap that arrives then also sets the done flag when it should not. A request held in the wrong state shows as `send_cs_req` disagreeing with `master_en` one cycle after a tick. Each of these is visible at the ports within one or two cycles of the stimulus.

// File: rtl/cycmon_pkg.sv
package cycmon_pkg;
    // Flag bit positions as seen by the host
    localparam int unsigned FLAG_STARTED = 0;
    localparam int unsigned FLAG_LOST    = 1;
    localparam int unsigned FLAG_DONE    = 2;
    localparam int unsigned NUM_FLAGS    = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_SEND = 2'd2
    } cyc_state_t;
endpackage

// File: rtl/cycmon_fsm.sv
module cycmon_fsm
    import cycmon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic master_en,
    input  logic cyc_tick,
    input  logic cs_sent,
    input  logic cs_rcvd,
    input  logic subact_gap,
    output logic send_cs_req,
    output logic cycle_pending,
    output logic ev_started,
    output logic ev_lost,
    output logic ev_done
);
    cyc_state_t state_q, state_d;
    cyc_state_t open_state;
    logic       strobe;

    assign strobe     = cs_sent | cs_rcvd;
    assign open_state = master_en ? ST_SEND : ST_WAIT;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cyc_tick) state_d = open_state;
            end
            ST_WAIT: begin
                if (cyc_tick)    state_d = open_state;
                else if (strobe) state_d = ST_IDLE;
            end
            ST_SEND: begin
                if (cyc_tick)        state_d = open_state;
                else if (strobe)     state_d = ST_IDLE;
                else if (!master_en) state_d = ST_WAIT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from state, events from state and inputs
    always_comb begin
        send_cs_req   = 1'b0;
        cycle_pending = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_WAIT: cycle_pending = 1'b1;
            ST_SEND: begin
                cycle_pending = 1'b1;
                send_cs_req   = 1'b1;
            end
            default: ;
        endcase
        ev_started = strobe;
        ev_lost    = cycle_pending & cyc_tick & ~strobe;
        ev_done    = subact_gap & ~cycle_pending;
    end

    assert_req_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        send_cs_req |-> cycle_pending);
    assert_tick_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_tick |=> cycle_pending);
    assert_master_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_tick && master_en) |=> send_cs_req);
    assert_close_on_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_pending && strobe && !cyc_tick) |=> !cycle_pending);
    assert_hold_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_pending && !strobe) |=> cycle_pending);
    assert_withdraw_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (send_cs_req && !master_en && !strobe && !cyc_tick) |=> (!send_cs_req && cycle_pending));
endmodule

// File: rtl/cycmon_flags.sv
module cycmon_flags #(
    parameter int unsigned WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_ev,
    input  logic [WIDTH-1:0] clr_w1c,
    output logic [WIDTH-1:0] flags
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flags[i] <= 1'b0;
            else        flags[i] <= set_ev[i] | (flags[i] & ~clr_w1c[i]);
        end

        assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
            set_ev[i] |=> flags[i]);
        assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && clr_w1c[i] && !set_ev[i]) |=> !flags[i]);
        assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && !clr_w1c[i]) |=> flags[i]);
    end
endmodule

// File: rtl/iso_cycle_monitor.sv
module iso_cycle_monitor
    import cycmon_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 master_en,
    input  logic                 cyc_tick,
    input  logic                 cs_sent,
    input  logic                 cs_rcvd,
    input  logic                 subact_gap,
    input  logic [NUM_FLAGS-1:0] irq_clr,
    output logic [NUM_FLAGS-1:0] irq_flags,
    output logic                 send_cs_req,
    output logic                 cycle_pending
);
    logic                 ev_started, ev_lost, ev_done;
    logic [NUM_FLAGS-1:0] set_vec;

    cycmon_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .master_en    (master_en),
        .cyc_tick     (cyc_tick),
        .cs_sent      (cs_sent),
        .cs_rcvd      (cs_rcvd),
        .subact_gap   (subact_gap),
        .send_cs_req  (send_cs_req),
        .cycle_pending(cycle_pending),
        .ev_started   (ev_started),
        .ev_lost      (ev_lost),
        .ev_done      (ev_done)
    );

    always_comb begin
        set_vec               = '0;
        set_vec[FLAG_STARTED] = ev_started;
        set_vec[FLAG_LOST]    = ev_lost;
        set_vec[FLAG_DONE]    = ev_done;
    end

    cycmon_flags #(.WIDTH(NUM_FLAGS)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_ev (set_vec),
        .clr_w1c(irq_clr),
        .flags  (irq_flags)
    );

    assert_done_outside_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (subact_gap && cycle_pending && !irq_flags[FLAG_DONE]) |=> !irq_flags[FLAG_DONE]);
    assert_no_loss_on_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((cs_sent || cs_rcvd) && !irq_flags[FLAG_LOST]) |=> !irq_flags[FLAG_LOST]);
endmodule

// File: tb/test_iso_cycle_monitor.sv
module test_iso_cycle_monitor;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       master_en = 1'b0;
    logic       cyc_tick = 1'b0;
    logic       cs_sent = 1'b0;
    logic       cs_rcvd = 1'b0;
    logic       subact_gap = 1'b0;
    logic [2:0] irq_clr = 3'b000;
    logic [2:0] irq_flags;
    logic       send_cs_req;
    logic       cycle_pending;

    int n_checks = 0;
    int n_fail   = 0;
    bit done_flag = 1'b0;

    always #4 clk = ~clk;

    iso_cycle_monitor i_iso_cycle_monitor (
        .clk(clk), .rst_n(rst_n), .master_en(master_en), .cyc_tick(cyc_tick),
        .cs_sent(cs_sent), .cs_rcvd(cs_rcvd), .subact_gap(subact_gap),
        .irq_clr(irq_clr), .irq_flags(irq_flags), .send_cs_req(send_cs_req),
        .cycle_pending(cycle_pending)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive inputs for one cycle from a falling edge; outputs are valid on return
    task automatic pulse(input bit tk, input bit snt, input bit rcv, input bit gap, input logic [2:0] clr);
        cyc_tick = tk; cs_sent = snt; cs_rcvd = rcv; subact_gap = gap; irq_clr = clr;
        @(negedge clk);
        cyc_tick = 1'b0; cs_sent = 1'b0; cs_rcvd = 1'b0; subact_gap = 1'b0; irq_clr = 3'b000;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic clear_all();
        pulse(0, 0, 0, 0, 3'b111);
    endtask

    task automatic t_reset();
        chk("R1", "flags", irq_flags, 0);
        chk("R1", "pending", cycle_pending, 0);
        chk("R1", "req", send_cs_req, 0);
    endtask

    task automatic t_slave_window();
        master_en = 1'b0;
        pulse(1, 0, 0, 0, 3'b000);
        chk("R2", "pending after tick", cycle_pending, 1);
        chk("R3", "no req when not master", send_cs_req, 0);
        idle(5);
        chk("R2", "pending held", cycle_pending, 1);
        pulse(0, 0, 1, 0, 3'b000);
        chk("R2", "pending closed", cycle_pending, 0);
        chk("R4", "started on receive", irq_flags, 3'b001);
        clear_all();
        chk("R8", "cleared", irq_flags, 0);
    endtask

    task automatic t_master();
        master_en = 1'b1;
        pulse(1, 0, 0, 0, 3'b000);
        chk("R3", "req on master tick", send_cs_req, 1);
        chk("R2", "pending master", cycle_pending, 1);
        idle(2);
        chk("R3", "req held", send_cs_req, 1);
        pulse(0, 1, 0, 0, 3'b000);
        chk("R3", "req dropped after sent", send_cs_req, 0);
        chk("R2", "pending dropped", cycle_pending, 0);
        chk("R4", "started on sent", irq_flags, 3'b001);
        clear_all();
        master_en = 1'b0;
    endtask

    task automatic t_lost();
        pulse(1, 0, 0, 0, 3'b000);
        idle(3);
        chk("R5", "no loss yet", irq_flags, 0);
        pulse(1, 0, 0, 0, 3'b000);
        chk("R5", "lost flag", irq_flags, 3'b010);
        chk("R5", "new window pending", cycle_pending, 1);
        pulse(0, 0, 1, 0, 3'b000);
        chk("R5", "window closed", cycle_pending, 0);
        clear_all();
    endtask

    task automatic t_same_cycle();
        pulse(1, 0, 0, 0, 3'b000);
        pulse(1, 0, 1, 0, 3'b000);
        chk("R6", "no loss, started only", irq_flags, 3'b001);
        chk("R6", "new window open", cycle_pending, 1);
        pulse(0, 0, 1, 0, 3'b000);
        clear_all();
    endtask

    task automatic t_done();
        pulse(0, 0, 0, 1, 3'b000);
        chk("R7", "done outside window", irq_flags, 3'b100);
        clear_all();
        pulse(1, 0, 0, 0, 3'b000);
        pulse(0, 0, 0, 1, 3'b000);
        chk("R7", "gap inside window ignored", irq_flags, 0);
        pulse(0, 0, 1, 0, 3'b000);
        clear_all();
    endtask

    task automatic t_w1c();
        pulse(0, 0, 1, 1, 3'b000);
        chk("R8", "two flags set", irq_flags, 3'b101);
        pulse(0, 0, 0, 0, 3'b001);
        chk("R8", "clear bit 0 only", irq_flags, 3'b100);
        pulse(0, 0, 0, 0, 3'b000);
        chk("R8", "zero write no effect", irq_flags, 3'b100);
        clear_all();
    endtask

    task automatic t_set_wins();
        pulse(0, 0, 1, 0, 3'b001);
        chk("R9", "set beats clear", irq_flags, 3'b001);
        chk("R4", "stray strobe leaves no window", cycle_pending, 0);
        clear_all();
    endtask

    task automatic t_withdraw();
        master_en = 1'b1;
        pulse(1, 0, 0, 0, 3'b000);
        chk("R10", "req before withdraw", send_cs_req, 1);
        master_en = 1'b0;
        @(negedge clk);
        chk("R10", "req withdrawn", send_cs_req, 0);
        chk("R10", "pending kept", cycle_pending, 1);
        pulse(0, 0, 1, 0, 3'b000);
        clear_all();
    endtask

    initial begin
        idle(2);
        t_reset();
        rst_n = 1'b1;
        idle(1);
        t_slave_window();
        t_master();
        t_lost();
        t_same_cycle();
        t_done();
        t_w1c();
        t_set_wins();
        t_withdraw();
        done_flag = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done_flag) break;
        end
        if (!done_flag) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule